// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits at the issue point of an in-order, two-wide pipeline whose two execution pipes are not alike. Each cycle it looks at the two oldest decoded instructions, the older in slot 0 and the younger in slot 1. It decides whether both can leave together or only the older one can. When both issue, the older goes to the primary pipe (U) and the younger to the secondary pipe (V). When only one issues, the instruction buffer upstream keeps the younger instruction, and that instruction becomes slot 0 on the next cycle.

The decision uses only a 4-bit class code for each instruction, the full-register indices the younger instruction reads, and the register that each instruction writes. A write is described by a full-register index and a byte-lane mask. A mask of all ones is a full write, a mask of zero means no write, and any other value is a partial write. The result is registered, so it appears one clock after the slot contents are presented. The issue count doubles as the number of entries the buffer should pop.

Class codes: 0 move, 1 address computation, 2 simple ALU, 3 push/pop, 4 test/compare (all pipe-neutral); 5 shift/rotate, 6 primary-pipe float (U only); 7 jump, 8 conditional branch, 9 call, 10 register exchange (V only); 11 multiply, 12 divide, 13 push-all, 14 string move, 15 solo float (never paired).

Top module: `pair_issue`

## Requirements
- R1: While reset is high and on the first cycle after it, issueCount is 0 and uValid, vValid and vHoldsOlder are all 0.
- R2: The decision for the slot contents presented before a rising edge appears on the outputs after that edge. issueCount is never above 2, and issueCount equals 2 exactly when uValid and vValid are both 1.
- R3: If slot 0 is empty, issueCount is 0 and no pipe is valid. If slot 0 is valid and slot 1 is empty, issueCount is 1 whatever slot 1's fields hold.
- R4: If the older instruction writes (lane mask non-zero) and a valid source of the younger one carries the same register index, issueCount is 1.
- R5: If both instructions write the same register index with lane masks that overlap, issueCount is 1.
- R6: If both instructions write the same register index with non-zero lane masks that do not overlap (for example lane 0 against lane 1), issueCount is 1.
- R7: If either instruction has a class code from 11 to 15, issueCount is 1.
- R8: Pairing needs the older class to be U-capable (codes 0 to 6) and the younger class to be V-capable (codes 0 to 4 or 7 to 10). Otherwise issueCount is 1.
- R9: When issueCount is 1, the older instruction goes to V (vValid=1, vHoldsOlder=1, uValid=0) if its class is 7 to 10. Otherwise it goes to U (uValid=1, vValid=0, vHoldsOlder=0).
- R10: When both slots are valid and none of R4 to R8 blocks the pair, issueCount is 2, uValid and vValid are 1, and vHoldsOlder is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s0Valid | input | 1 | Older slot holds an instruction |
| s0Class | input | 4 | Older instruction class code |
| s0Dst | input | REG_W | Older destination full-register index |
| s0Lanes | input | LANES | Older written byte lanes (0 = no write) |
| s1Valid | input | 1 | Younger slot holds an instruction |
| s1Class | input | 4 | Younger instruction class code |
| s1SrcA | input | REG_W | Younger first source index |
| s1SrcAVld | input | 1 | First source is read |
| s1SrcB | input | REG_W | Younger second source index |
| s1SrcBVld | input | 1 | Second source is read |
| s1Dst | input | REG_W | Younger destination full-register index |
| s1Lanes | input | LANES | Younger written byte lanes (0 = no write) |
| issueCount | output | 2 | Instructions issued and entries to pop (0, 1, 2) |
| uValid | output | 1 | Primary pipe receives the older instruction |
| vValid | output | 1 | Secondary pipe receives an instruction |
| vHoldsOlder | output | 1 | Secondary pipe carries the older instruction alone |

## Verification
The bench goes after disjoint partial writes to one register. A design that compared only overlapping lanes would pair them and corrupt the merged value. It sweeps source indices against the older destination, including the case where the older instruction writes nothing. A design that ignored the lane mask would stall needlessly, and one that ignored source-valid bits would miss true hazards. The full 16-by-16 class grid covers the asymmetric pipe rules. There, a reversed capability check would send a branch into U or a shift into V. A wrong single-issue placement would leave a lone jump in the primary pipe.

// File: rtl/pair_pkg.sv
package pair_pkg;

  localparam int CLASS_W = 4;

  typedef enum logic [CLASS_W-1:0] {
    CL_MOVE    = 4'd0,
    CL_ADDR    = 4'd1,
    CL_ALU     = 4'd2,
    CL_STACK   = 4'd3,
    CL_CMP     = 4'd4,
    CL_SHIFT   = 4'd5,
    CL_FPU_U   = 4'd6,
    CL_JUMP    = 4'd7,
    CL_BRANCH  = 4'd8,
    CL_CALL    = 4'd9,
    CL_XCHG    = 4'd10,
    CL_MUL     = 4'd11,
    CL_DIV     = 4'd12,
    CL_PUSHALL = 4'd13,
    CL_STRMOV  = 4'd14,
    CL_FPU_SOLO = 4'd15
  } insnClass_e;

  // Hazard strobes handed from the compare datapath to the issue control.
  typedef struct packed {
    logic raw;
    logic waw;
    logic laneClash;
  } hazStrobes_t;

  function automatic logic isSolo(input logic [CLASS_W-1:0] c);
    return c >= CL_MUL;
  endfunction

  function automatic logic isVOnly(input logic [CLASS_W-1:0] c);
    return (c >= CL_JUMP) && (c <= CL_XCHG);
  endfunction

  function automatic logic canPrimary(input logic [CLASS_W-1:0] c);
    return c <= CL_FPU_U;
  endfunction

  function automatic logic canSecondary(input logic [CLASS_W-1:0] c);
    return (c <= CL_CMP) || isVOnly(c);
  endfunction

endpackage

// File: rtl/pair_hazard.sv
module pair_hazard
  import pair_pkg::*;
#(
  parameter int REG_W = 3,
  parameter int LANES = 2,
  parameter int NSRC  = 2
) (
  input  logic [REG_W-1:0]           olderDst,
  input  logic [LANES-1:0]           olderLanes,
  input  logic [REG_W-1:0]           youngerDst,
  input  logic [LANES-1:0]           youngerLanes,
  input  logic [NSRC-1:0][REG_W-1:0] youngerSrc,
  input  logic [NSRC-1:0]            youngerSrcVld,
  output hazStrobes_t                haz
);

  logic [NSRC-1:0] srcHit;
  logic olderWrites, youngerWrites, sameDst, lanesOverlap;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign srcHit[g] = youngerSrcVld[g] && (youngerSrc[g] == olderDst);
  end

  always_comb begin
    olderWrites   = |olderLanes;
    youngerWrites = |youngerLanes;
    sameDst       = olderDst == youngerDst;
    lanesOverlap  = |(olderLanes & youngerLanes);
    haz.raw       = olderWrites && (|srcHit);
    haz.waw       = sameDst && lanesOverlap;
    haz.laneClash = sameDst && olderWrites && youngerWrites && !lanesOverlap;
  end

endmodule

// File: rtl/pair_ctrl.sv
module pair_ctrl
  import pair_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               s0Valid,
  input  logic [CLASS_W-1:0] s0Class,
  input  logic               s1Valid,
  input  logic [CLASS_W-1:0] s1Class,
  input  hazStrobes_t        haz,
  output logic [1:0]         issueCount,
  output logic               uValid,
  output logic               vValid,
  output logic               vHoldsOlder
);

  logic pairOk, olderToV, singleOnly;

  always_comb begin
    pairOk = s0Valid && s1Valid
          && !haz.raw && !haz.waw && !haz.laneClash
          && !isSolo(s0Class) && !isSolo(s1Class)
          && canPrimary(s0Class) && canSecondary(s1Class);
    olderToV   = isVOnly(s0Class);
    singleOnly = s0Valid && !pairOk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issueCount  <= 2'd0;
      uValid      <= 1'b0;
      vValid      <= 1'b0;
      vHoldsOlder <= 1'b0;
    end else begin
      issueCount  <= pairOk ? 2'd2 : (s0Valid ? 2'd1 : 2'd0);
      uValid      <= pairOk || (singleOnly && !olderToV);
      vValid      <= pairOk || (singleOnly && olderToV);
      vHoldsOlder <= singleOnly && olderToV;
    end
  end

  p_dual_both_pipes_r2: assert property (@(posedge clk) disable iff (rst)
    (issueCount == 2'd2) == (uValid && vValid));

  p_empty_slot0_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(s0Valid)) |-> (issueCount == 2'd0 && !uValid && !vValid));

  p_raw_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(haz.raw)) |-> (issueCount != 2'd2));

  p_waw_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(haz.waw)) |-> (issueCount != 2'd2));

  p_lane_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(haz.laneClash)) |-> (issueCount != 2'd2));

  p_solo_alone_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(isSolo(s0Class) || isSolo(s1Class))) |-> (issueCount != 2'd2));

  p_vonly_not_u_r9: assert property (@(posedge clk) disable iff (rst)
    uValid |-> !$past(isVOnly(s0Class)));

  p_hold_single_r9: assert property (@(posedge clk) disable iff (rst)
    vHoldsOlder |-> (issueCount == 2'd1 && !uValid));

endmodule

// File: rtl/pair_issue.sv
module pair_issue
  import pair_pkg::*;
#(
  parameter int REG_W = 3,
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               s0Valid,
  input  logic [CLASS_W-1:0] s0Class,
  input  logic [REG_W-1:0]   s0Dst,
  input  logic [LANES-1:0]   s0Lanes,
  input  logic               s1Valid,
  input  logic [CLASS_W-1:0] s1Class,
  input  logic [REG_W-1:0]   s1SrcA,
  input  logic               s1SrcAVld,
  input  logic [REG_W-1:0]   s1SrcB,
  input  logic               s1SrcBVld,
  input  logic [REG_W-1:0]   s1Dst,
  input  logic [LANES-1:0]   s1Lanes,
  output logic [1:0]         issueCount,
  output logic               uValid,
  output logic               vValid,
  output logic               vHoldsOlder
);

  localparam int NSRC = 2;

  hazStrobes_t haz;

  pair_hazard #(.REG_W(REG_W), .LANES(LANES), .NSRC(NSRC)) u_hazard (
    .olderDst      (s0Dst),
    .olderLanes    (s0Lanes),
    .youngerDst    (s1Dst),
    .youngerLanes  (s1Lanes),
    .youngerSrc    ({s1SrcB, s1SrcA}),
    .youngerSrcVld ({s1SrcBVld, s1SrcAVld}),
    .haz           (haz)
  );

  pair_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .s0Valid     (s0Valid),
    .s0Class     (s0Class),
    .s1Valid     (s1Valid),
    .s1Class     (s1Class),
    .haz         (haz),
    .issueCount  (issueCount),
    .uValid      (uValid),
    .vValid      (vValid),
    .vHoldsOlder (vHoldsOlder)
  );

endmodule

// File: tb/sim_pair_issue.sv
module sim_pair_issue;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       s0Valid = 1'b0, s1Valid = 1'b0;
  logic [3:0] s0Class = '0, s1Class = '0;
  logic [2:0] s0Dst = '0, s1Dst = '0, s1SrcA = '0, s1SrcB = '0;
  logic       s1SrcAVld = 1'b0, s1SrcBVld = 1'b0;
  logic [1:0] s0Lanes = '0, s1Lanes = '0;
  logic [1:0] issueCount;
  logic       uValid, vValid, vHoldsOlder;

  int vectors = 0;
  int misses  = 0;

  always #5 clk = ~clk;

  pair_issue u0 (.*);

  // Expected result {count[1:0], u, v, hold} and the requirement that decides it.
  function automatic logic [4:0] model(output string tag);
    logic raw, same, solo, caps;
    logic vOnly;
    vOnly = (s0Class >= 4'd7) && (s0Class <= 4'd10);
    if (!s0Valid) begin tag = "R3"; return 5'b00_000; end
    raw  = (s0Lanes != 0) && ((s1SrcAVld && s1SrcA == s0Dst) || (s1SrcBVld && s1SrcB == s0Dst));
    same = (s0Lanes != 0) && (s1Lanes != 0) && (s0Dst == s1Dst);
    solo = (s0Class >= 4'd11) || (s1Class >= 4'd11);
    caps = (s0Class <= 4'd6) && ((s1Class <= 4'd4) || (s1Class >= 4'd7 && s1Class <= 4'd10));
    if (!s1Valid) tag = "R3";
    else if (raw) tag = "R4";
    else if (same && (s0Lanes & s1Lanes) != 0) tag = "R5";
    else if (same) tag = "R6";
    else if (solo) tag = "R7";
    else if (!caps) tag = "R8";
    else begin tag = "R10"; return 5'b10_110; end
    if (tag == "R8" || tag == "R3") tag = {tag, "/R9"};
    return vOnly ? 5'b01_011 : 5'b01_100;
  endfunction

  task automatic checkOut(input logic [4:0] exp, input string tag);
    logic [4:0] act;
    act = {issueCount, uValid, vValid, vHoldsOlder};
    vectors++;
    if (act !== exp || issueCount == 2'd3) begin
      misses++;
      $display("FAIL %s actual=%b expected=%b (c0=%0d c1=%0d)", tag, act, exp, s0Class, s1Class);
    end
  endtask

  task automatic applyOne();
    string tag;
    logic [4:0] exp;
    exp = model(tag);
    @(posedge clk);
    @(negedge clk);
    checkOut(exp, {tag, " R2"});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    // R1: reset state
    s0Valid = 1'b1; s1Valid = 1'b1;
    repeat (3) @(negedge clk);
    checkOut(5'b00_000, "R1 in reset");
    rst = 1'b0;
    s0Valid = 1'b0; s1Valid = 1'b0;
    @(negedge clk);
    checkOut(5'b00_000, "R1 after reset");

    // Class grid with no register hazards (R7, R8, R9, R10, R3)
    s0Dst = 3'd1; s0Lanes = 2'b11;
    s1SrcA = 3'd2; s1SrcAVld = 1'b1; s1SrcB = 3'd3; s1SrcBVld = 1'b1;
    s1Dst = 3'd4; s1Lanes = 2'b11;
    for (int v = 0; v < 4; v++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          @(negedge clk);
          s0Valid = v[0]; s1Valid = v[1];
          s0Class = 4'(a); s1Class = 4'(b);
          applyOne();
        end
      end
    end

    // Register and lane sweep with pairable ALU classes (R3, R4, R5, R6, R10)
    s0Class = 4'd2; s1Class = 4'd2; s0Valid = 1'b1;
    s1SrcB = 3'd6; s1SrcBVld = 1'b0;
    for (int sv = 0; sv < 2; sv++)
      for (int d0 = 0; d0 < 8; d0++)
        for (int d1 = 0; d1 < 4; d1++)
          for (int l0 = 0; l0 < 4; l0++)
            for (int l1 = 0; l1 < 4; l1++)
              for (int sr = 0; sr < 8; sr++)
                for (int srv = 0; srv < 2; srv++) begin
                  @(negedge clk);
                  s1Valid = sv[0];
                  s0Dst = 3'(d0); s1Dst = 3'(d1);
                  s0Lanes = 2'(l0); s1Lanes = 2'(l1);
                  s1SrcA = 3'(sr); s1SrcAVld = srv[0];
                  applyOne();
                end

    // Second source alone creating the dependence (R4)
    @(negedge clk);
    s1Valid = 1'b1; s0Dst = 3'd5; s0Lanes = 2'b01; s1Dst = 3'd0; s1Lanes = 2'b11;
    s1SrcAVld = 1'b0; s1SrcB = 3'd5; s1SrcBVld = 1'b1;
    applyOne();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule